// File: doc/BRIEF.md
# Clock-Generator Configuration Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target that holds the configuration of a clock generator. It has six one-byte registers. A host loads them with block writes on one 8-bit device address and reads them back with block reads on the next address. Each write carries two leading bytes, a command byte and a count byte. The block acknowledges both and discards their contents. Data bytes then fill registers 0 to 5 in order, and the host may stop after any complete byte. A read returns a byte count first, followed by the six register images.

The block runs on a system clock at least eight times faster than SCL. It resynchronises SCL and SDA, finds edges, start and stop conditions, and pulls SDA low through an open-drain enable. The register contents drive the configuration outputs directly. These outputs are a 4-bit frequency-select code, the spread-spectrum controls, an all-outputs-off request and four per-output enable masks. The frequency-select code comes from one of two sources. The first is a set of strap pins, sampled while reset is asserted. The second is four register bits that are not next to each other.

Top module: `cfg_i2c_slave`

## Requirements
- R1: A first byte of 0xD2 (write) or 0xD3 (read) is acknowledged by holding SDA low during the ninth SCL pulse. Any other first byte is not acknowledged, and the block ignores the bus until the next start condition.
- R2: In a write, the two bytes after the address byte are both acknowledged and have no effect on any register.
- R3: Write data bytes go to registers 0, 1, 2, 3, 4, 5 in order, and each is acknowledged. A stop after any complete byte ends loading. A partly sent byte is not stored.
- R4: Write data bytes after the sixth are acknowledged and discarded.
- R5: A read returns 0x06 first, then registers 0 to 5. Each further byte is sent after a host acknowledge. A host not-acknowledge ends the read and releases SDA. Bytes requested after register 5 read as 0xFF.
- R6: Register 0 bit 3 picks the frequency source. With 0, freq_code equals the latched strap_fs. With 1, freq_code = {bit2, bit6, bit5, bit4}, and freq_from_reg shows the choice. Bit 7 drives spread_down, bit 1 drives spread_en and bit 0 drives outputs_off.
- R7: After reset, register 0 is 0x20 (register code 0010, all other bits 0). Registers 1, 2, 3 and 5 are 0xFF.
- R8: strap_fs and strap_sel are sampled only while rst_n is low and held after it. Register 4 is read-only: it reads {1, 1, ~sel, 1, ~fs[1], 1, ~fs[3], 1} from bit 7 down to bit 0, and writes to it change nothing.
- R9: cpu_en, pci_en, sdram_en and periph_en equal registers 1, 2, 3 and 5. A set bit enables an output.
- R10: sda_oe changes only while SCL is low, and a stop condition releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low reset; straps are sampled while low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_fs | input | 4 | Frequency-select strap pins |
| strap_sel | input | 1 | 24/48 select strap pin |
| freq_code | output | 4 | Active frequency-select code |
| freq_from_reg | output | 1 | 1 when freq_code comes from register bits |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_down | output | 1 | 1 = down spread, 0 = centre spread |
| outputs_off | output | 1 | Request to float all clock outputs |
| cpu_en | output | 8 | Processor-clock enables (register 1) |
| pci_en | output | 8 | Bus-clock enables (register 2) |
| sdram_en | output | 8 | Memory-clock enables (register 3) |
| periph_en | output | 8 | Peripheral-clock enables (register 5) |

## Verification
The hardest states to reach are the ones where the host abandons a transfer partway. Examples are a stop in the middle of a data bit after the two dummy bytes, a not-acknowledge in the middle of a read, and a write that runs past register 5. In each case the bus must return to idle with no stray commit and no SDA still held low. The bench's bit-level host model can stop after any number of bits and can choose its own acknowledge value. Directed sequences force each of these abandon points. Random transfers of 0 to 9 data bytes are mixed in, and each is followed by a full read-back checked against a bench register model.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
    localparam int NUM_REGS = 6;
    localparam int RO_REG   = 4;
    localparam int SKIP     = 2;
    localparam int IDX_W    = $clog2(NUM_REGS + SKIP + 1);

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [7:0]       byte_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_HACK
    } link_st_e;
endpackage

// File: rtl/cfgi2c_line_sync.sv
module cfgi2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_p;
        logic [STAGES-1:0] sda_p;
        logic              scl_l;
        logic              sda_l;
    } sync_t;

    sync_t d, q;
    logic  scl_s;

    always_comb begin
        d       = q;
        d.scl_p = {q.scl_p[STAGES-2:0], scl_i};
        d.sda_p = {q.sda_p[STAGES-2:0], sda_i};
        d.scl_l = q.scl_p[STAGES-1];
        d.sda_l = q.sda_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_p[STAGES-1];
    assign sda_s     = q.sda_p[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_l;
    assign scl_fall  = ~scl_s & q.scl_l;
    assign start_det = scl_s & q.scl_l & q.sda_l & ~sda_s;
    assign stop_det  = scl_s & q.scl_l & ~q.sda_l & sda_s;
endmodule

// File: rtl/cfgi2c_link.sv
module cfgi2c_link
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sda_s,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  start_det,
    input  logic  stop_det,
    input  byte_t rd_data,
    output idx_t  rd_idx,
    output logic  wr_en,
    output idx_t  wr_idx,
    output byte_t wr_data,
    output logic  sda_oe
);
    localparam idx_t WR_LAST = idx_t'(NUM_REGS + SKIP);
    localparam idx_t RD_LAST = idx_t'(NUM_REGS + 1);

    typedef struct packed {
        link_st_e st;
        logic [3:0] cnt;
        byte_t    sh;
        logic     rw;
        idx_t     idx;
        logic     oe;
        logic     nack;
    } link_t;

    link_t d, q;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = idx_t'(q.idx - idx_t'(SKIP));
        wr_data = q.sh;
        if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
            d.idx = '0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.rw = q.sh[0];
                                d.oe = 1'b1;
                                d.st = ST_ACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            wr_en = (q.idx >= idx_t'(SKIP)) && (q.idx < WR_LAST);
                            if (q.idx != WR_LAST) d.idx = q.idx + idx_t'(1);
                            d.oe = 1'b1;
                            d.st = ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh = rd_data;
                            d.oe = ~rd_data[7];
                            d.st = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = ST_HACK;
                            if (q.idx != RD_LAST) d.idx = q.idx + idx_t'(1);
                        end else begin
                            d.sh = {q.sh[6:0], 1'b1};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[7];
                            d.cnt = '0;
                            d.st  = ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign rd_idx = q.idx;
    assign sda_oe = q.oe;
endmodule

// File: rtl/cfgi2c_regfile.sv
module cfgi2c_regfile
    import cfgi2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] strap_fs,
    input  logic       strap_sel,
    input  logic       wr_en,
    input  idx_t       wr_idx,
    input  byte_t      wr_data,
    input  idx_t       rd_idx,
    output byte_t      rd_data,
    output logic [NUM_REGS-1:0][7:0] regs
);
    localparam byte_t CTRL_RST = 8'h20;

    logic [NUM_REGS-1:0][7:0] mem_d, mem_q;
    logic [3:0] fs_l;
    logic       sel_l;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_l  <= strap_fs;
            sel_l <= strap_sel;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        if (g == RO_REG) begin : g_ro
            assign mem_d[g] = {2'b11, ~sel_l, 1'b1, ~fs_l[1], 1'b1, ~fs_l[3], 1'b1};
        end else begin : g_rw
            assign mem_d[g] = (wr_en && wr_idx == idx_t'(g)) ? wr_data : mem_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q    <= '1;
            mem_q[0] <= CTRL_RST;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        if (rd_idx == '0) begin
            rd_data = byte_t'(NUM_REGS);
        end else begin
            for (int i = 0; i < NUM_REGS; i++)
                if (rd_idx == idx_t'(i + 1)) rd_data = mem_q[i];
        end
    end

    always_comb begin
        regs    = mem_q;
        regs[0] = mem_q[0];
        if (!mem_q[0][3]) regs[0] = {mem_q[0][7], fs_l[2:0], mem_q[0][3], fs_l[3], mem_q[0][1:0]};
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [3:0] strap_fs,
    input  logic       strap_sel,
    output logic [3:0] freq_code,
    output logic       freq_from_reg,
    output logic       spread_en,
    output logic       spread_down,
    output logic       outputs_off,
    output logic [7:0] cpu_en,
    output logic [7:0] pci_en,
    output logic [7:0] sdram_en,
    output logic [7:0] periph_en
);
    logic  sda_s, scl_rise, scl_fall, start_det, stop_det, wr_en;
    idx_t  rd_idx, wr_idx;
    byte_t rd_data, wr_data;
    logic [NUM_REGS-1:0][7:0] regs;

    cfgi2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfgi2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    cfgi2c_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .strap_sel(strap_sel),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .regs(regs)
    );

    // regs[0] already carries the strap code in the code bit positions when bit 3 is clear
    assign freq_code     = {regs[0][2], regs[0][6], regs[0][5], regs[0][4]};
    assign freq_from_reg = regs[0][3];
    assign spread_down   = regs[0][7];
    assign spread_en     = regs[0][1];
    assign outputs_off   = regs[0][0];
    assign cpu_en        = regs[1];
    assign pci_en        = regs[2];
    assign sdram_en      = regs[3];
    assign periph_en     = regs[5];
endmodule

module cfg_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       stop_det,
    input logic [3:0] freq_code,
    input logic       freq_from_reg,
    input logic [7:0] cpu_en,
    input logic [7:0] pci_en,
    input logic [7:0] sdram_en,
    input logic [7:0] periph_en
);
    p_ack_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    p_load_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cpu_en, pci_en, sdram_en, periph_en, freq_from_reg}) |-> !scl_i);

    p_strap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!freq_from_reg && $past(!freq_from_reg)) |-> $stable(freq_code));

    p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .stop_det(stop_det),
    .freq_code(freq_code), .freq_from_reg(freq_from_reg), .cpu_en(cpu_en),
    .pci_en(pci_en), .sdram_en(sdram_en), .periph_en(periph_en)
);

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;
    localparam int Q = 50;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [3:0] strap_fs = 4'b1010;
    logic strap_sel = 1'b0;
    logic sda_oe, freq_from_reg, spread_en, spread_down, outputs_off;
    logic [3:0] freq_code;
    logic [7:0] cpu_en, pci_en, sdram_en, periph_en;
    wire sda_line = m_sda & ~sda_oe;

    int checks = 0, errors = 0;
    logic [7:0] exp_mem [0:5];
    logic [7:0] buffer [0:9];

    always #5 clk = ~clk;

    cfg_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_fs(strap_fs), .strap_sel(strap_sel), .freq_code(freq_code),
        .freq_from_reg(freq_from_reg), .spread_en(spread_en), .spread_down(spread_down),
        .outputs_off(outputs_off), .cpu_en(cpu_en), .pci_en(pci_en),
        .sdram_en(sdram_en), .periph_en(periph_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_read(input int i);
        if (i == 0) return 8'h06;
        if (i == 5) return {2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
        if (i <= 6) return exp_mem[i-1];
        return 8'hFF;
    endfunction

    function automatic logic [3:0] exp_code();
        if (exp_mem[0][3]) return {exp_mem[0][2], exp_mem[0][6], exp_mem[0][5], exp_mem[0][4]};
        return 4'b1010;
    endfunction

    task automatic wbit(input logic b);
        m_sda = b; #(Q); m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #(Q);
    endtask
    task automatic rbit(output logic b);
        m_sda = 1'b1; #(Q); m_scl = 1'b1; #(Q); b = sda_line; #(Q); m_scl = 1'b0; #(Q);
    endtask
    task automatic i2c_start();
        m_sda = 1'b1; #(Q); m_scl = 1'b1; #(Q); m_sda = 1'b0; #(Q); m_scl = 1'b0; #(Q);
    endtask
    task automatic i2c_stop();
        m_sda = 1'b0; #(Q); m_scl = 1'b1; #(Q); m_sda = 1'b1; #(2*Q);
    endtask
    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = ~a;
    endtask
    task automatic recv_byte(output logic [7:0] v, input logic host_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
        wbit(~host_ack);
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " R6 code"}, freq_code, exp_code());
        chk({tag, " R6 src"}, freq_from_reg, exp_mem[0][3]);
        chk({tag, " R6 ctl"}, {spread_down, spread_en, outputs_off},
            {exp_mem[0][7], exp_mem[0][1], exp_mem[0][0]});
        chk({tag, " R9 masks"}, {cpu_en, pci_en, sdram_en, periph_en},
            {exp_mem[1], exp_mem[2], exp_mem[3], exp_mem[5]});
    endtask

    task automatic write_txn(input int n);
        logic ack;
        i2c_start();
        send_byte(8'hD2, ack); chk("R1 write address ack", ack, 1'b1);
        send_byte(8'h5A, ack); chk("R2 command ack", ack, 1'b1);
        send_byte(8'hC3, ack); chk("R2 count ack", ack, 1'b1);
        for (int k = 0; k < n; k++) begin
            send_byte(buffer[k], ack);
            chk(k < 6 ? "R3 data ack" : "R4 extra ack", ack, 1'b1);
            if (k < 6 && k != 4) exp_mem[k] = buffer[k];
        end
        i2c_stop();
    endtask

    task automatic read_txn(input int n);
        logic ack;
        logic [7:0] v;
        i2c_start();
        send_byte(8'hD3, ack); chk("R1 read address ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            chk(i == 5 ? "R8 readback" : "R5 read byte", v, exp_read(i));
        end
        i2c_stop();
        chk("R5 released after nack", sda_oe, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        void'($urandom(32'd20240611));
        exp_mem[0] = 8'h20;
        for (int i = 1; i < 6; i++) exp_mem[i] = 8'hFF;
        #100 rst_n = 1'b1;
        strap_fs = 4'b0101; strap_sel = 1'b1;
        #100;
        chk("R7 reset sda", sda_oe, 1'b0);
        check_outputs("R7 reset");
        chk("R8 strap held", freq_code, 4'b1010);
        read_txn(7);

        // full write, register source selected
        buffer[0] = 8'b1101_1011; buffer[1] = 8'h3C; buffer[2] = 8'hA5;
        buffer[3] = 8'h0F; buffer[4] = 8'h00; buffer[5] = 8'h96;
        write_txn(6);
        check_outputs("R3 full");
        read_txn(7);

        // partial write: only bytes 0 and 1
        buffer[0] = 8'h20; buffer[1] = 8'h11;
        write_txn(2);
        check_outputs("R3 partial");

        // past the end
        for (int k = 0; k < 9; k++) buffer[k] = 8'h40 + 8'(k);
        write_txn(9);
        check_outputs("R4 overrun");
        read_txn(9);

        // wrong address, then data that must be ignored
        i2c_start();
        send_byte(8'hA4, ack); chk("R1 no ack wrong address", ack, 1'b0);
        send_byte(8'h00, ack); chk("R1 ignored byte", ack, 1'b0);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        i2c_stop();
        check_outputs("R1 ignored");

        // stop in the middle of a data byte
        i2c_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        for (int i = 0; i < 4; i++) wbit(1'b0);
        i2c_stop();
        check_outputs("R3 half byte");

        // early nack on read, then a fresh read
        read_txn(2);
        read_txn(7);

        // random traffic
        for (int it = 0; it < 18; it++) begin
            int n;
            n = int'($urandom % 10);
            for (int k = 0; k < 10; k++) buffer[k] = 8'($urandom);
            write_txn(n);
            check_outputs("R6 random");
            read_txn(7);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule